// File: doc/BRIEF.md
# CAN Transmit Abort Sequencer

This block cancels a queued CAN transmission for a host without ever freeing the transmit buffer inside the two-bit-time window that comes just before a start of frame. It reads the buffer status flags (pending, on-bus and the controller's run status) and drives three controls: a stop request that parks the controller, a no-retransmit control, and a lock release for the transmit buffer. It never releases the lock while that window could be open.

A host starts a cancel with a one-cycle request and picks one of two paths with a mode bit. On the park path (`abort_mode` = 1), the block first asks the controller to stop. It releases the lock only after the controller reports that it has left the running state, which it does only after its current attempt ends. On the live path (`abort_mode` = 0), the controller keeps running. The block raises no-retransmit, so a frame that fails with a bus error is not sent again. It then waits for the current attempt to leave the bus. A frame that lost arbitration is still pending at that point, and the block releases the lock on the cycle right after the busy flag falls.

Both paths end with a one-cycle completion pulse. A result bit alongside the pulse tells whether a pending frame had to be freed. Requests that arrive while a sequence is running are ignored. All status inputs are taken as synchronous to `clk`.

Top module: `can_tx_abort_seq`

## Requirements
- R1: During reset and in the first cycle after it, `stop_req`, `no_retx`, `lock_release`, `done` and `cancelled` are all 0.
- R2: An `abort_req` seen at a clock edge with `abort_mode` = 1 in idle raises `stop_req` from the next cycle. `stop_req` stays high up to and including the cycle before `done`. `no_retx` stays 0 on this path.
- R3: On the park path, `lock_release` rises only in the cycle after an edge at which `run_status` was 0 and `tx_pending` was 1.
- R4: On the park path, if `tx_pending` is 0 at the edge where `run_status` is first seen 0, there is no lock release. `done` follows in the next cycle with `cancelled` = 0.
- R5: An `abort_req` seen in idle with `abort_mode` = 0 raises `no_retx` from the next cycle. `no_retx` stays high up to and including the cycle before `done`. `stop_req` stays 0 on this path.
- R6: On the live path, `lock_release` rises only in the cycle after the edge at which a falling edge of `tx_busy` is seen (high at the previous edge, low at this one) with `tx_pending` still 1.
- R7: On the live path, if `tx_pending` has dropped, there is no lock release and `done` comes with `cancelled` = 0. This happens in the cycle after `tx_busy` falls, or in the cycle after `tx_pending` is seen low while `tx_busy` has not been high.
- R8: Once raised, `lock_release` stays high until an edge sees `tx_pending` = 0. In the next cycle it is low and `done` is high with `cancelled` = 1.
- R9: `done` lasts exactly one cycle and is followed by idle. `cancelled` is never 1 without `done`.
- R10: `abort_req` is ignored in every cycle that is not idle, including the `done` cycle. It starts no second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_req | input | 1 | Cancel request, taken only in idle |
| abort_mode | input | 1 | 1 = park controller first, 0 = keep running |
| tx_pending | input | 1 | Transmit buffer holds a frame not yet sent |
| tx_busy | input | 1 | Controller is currently attempting the frame on the bus |
| run_status | input | 1 | Controller is in the running state (0 = standby) |
| stop_req | output | 1 | Asks the controller to stop after its current attempt |
| no_retx | output | 1 | Disables automatic retransmission after an error |
| lock_release | output | 1 | Frees the transmit buffer lock |
| done | output | 1 | One-cycle completion pulse |
| cancelled | output | 1 | With `done`: a pending frame was freed |

## Verification
The hardest case to reach is arbitration loss on the live path. Here `tx_busy` falls while `tx_pending` stays high, so the block must release the lock in exactly the cycle after the edge. It must not release it in the cycles before the edge, while the frame is still on the bus. The stimulus holds `tx_busy` high for several cycles with `tx_pending` high, then drops only `tx_busy`. A cycle-by-cycle model checks every output on every cycle. A second live-path case drops `tx_pending` during the busy phase, so the same falling edge must end the sequence without any release.

// File: rtl/can_tx_abort_pkg.sv
package can_tx_abort_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE      = 3'd0,
    ST_PARK_WAIT = 3'd1,
    ST_PARK_FREE = 3'd2,
    ST_LIVE_ARM  = 3'd3,
    ST_LIVE_EDGE = 3'd4,
    ST_LIVE_FREE = 3'd5,
    ST_END_HIT   = 3'd6,
    ST_END_MISS  = 3'd7
  } seq_state_t;

  function automatic logic on_park_path(input seq_state_t s);
    return (s == ST_PARK_WAIT) || (s == ST_PARK_FREE);
  endfunction

  function automatic logic on_live_path(input seq_state_t s);
    return (s == ST_LIVE_ARM) || (s == ST_LIVE_EDGE) || (s == ST_LIVE_FREE);
  endfunction

  function automatic logic in_free_phase(input seq_state_t s);
    return (s == ST_PARK_FREE) || (s == ST_LIVE_FREE);
  endfunction

  function automatic logic is_end(input seq_state_t s);
    return (s == ST_END_HIT) || (s == ST_END_MISS);
  endfunction
endpackage

// File: rtl/can_tx_busy_edge.sv
module can_tx_busy_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  output logic busy_fall
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_in;
  end

  assign busy_fall = busy_q & ~busy_in;
endmodule

// File: rtl/can_tx_abort_fsm.sv
module can_tx_abort_fsm
  import can_tx_abort_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_req,
  input  logic       abort_mode,
  input  logic       tx_pending,
  input  logic       tx_busy,
  input  logic       run_status,
  input  logic       busy_fall,
  output seq_state_t state
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (abort_req) nxt = abort_mode ? ST_PARK_WAIT : ST_LIVE_ARM;
      end
      ST_PARK_WAIT: begin
        if (!run_status) nxt = tx_pending ? ST_PARK_FREE : ST_END_MISS;
      end
      ST_PARK_FREE: begin
        if (!tx_pending) nxt = ST_END_HIT;
      end
      ST_LIVE_ARM: begin
        if (tx_busy)          nxt = ST_LIVE_EDGE;
        else if (!tx_pending) nxt = ST_END_MISS;
      end
      ST_LIVE_EDGE: begin
        if (busy_fall) nxt = tx_pending ? ST_LIVE_FREE : ST_END_MISS;
      end
      ST_LIVE_FREE: begin
        if (!tx_pending) nxt = ST_END_HIT;
      end
      ST_END_HIT, ST_END_MISS: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    is_end(state) |=> (state == ST_IDLE)); // R9
endmodule

// File: rtl/can_tx_abort_outputs.sv
module can_tx_abort_outputs
  import can_tx_abort_pkg::*;
(
  input  seq_state_t state,
  output logic       stop_req,
  output logic       no_retx,
  output logic       lock_release,
  output logic       done,
  output logic       cancelled
);
  always_comb begin
    stop_req     = on_park_path(state);
    no_retx      = on_live_path(state);
    lock_release = in_free_phase(state);
    done         = is_end(state);
    cancelled    = (state == ST_END_HIT);
  end
endmodule

// File: rtl/can_tx_abort_seq.sv
module can_tx_abort_seq
  import can_tx_abort_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic abort_req,
  input  logic abort_mode,
  input  logic tx_pending,
  input  logic tx_busy,
  input  logic run_status,
  output logic stop_req,
  output logic no_retx,
  output logic lock_release,
  output logic done,
  output logic cancelled
);
  logic       busy_fall;
  seq_state_t state;

  can_tx_busy_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_in   (tx_busy),
    .busy_fall (busy_fall)
  );

  can_tx_abort_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort_req  (abort_req),
    .abort_mode (abort_mode),
    .tx_pending (tx_pending),
    .tx_busy    (tx_busy),
    .run_status (run_status),
    .busy_fall  (busy_fall),
    .state      (state)
  );

  can_tx_abort_outputs u_out (
    .state        (state),
    .stop_req     (stop_req),
    .no_retx      (no_retx),
    .lock_release (lock_release),
    .done         (done),
    .cancelled    (cancelled)
  );

  AST_PARK_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(abort_req && abort_mode)); // R2
  AST_PARK_FREE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_release) && stop_req) |-> $past(!run_status && tx_pending)); // R3
  AST_LIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_retx) |-> $past(abort_req && !abort_mode)); // R5
  AST_LIVE_FREE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lock_release) && no_retx) |-> $past(busy_fall && tx_pending)); // R6
  AST_HIT_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cancelled |-> $past(lock_release && !tx_pending)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_CANCEL_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cancelled |-> done); // R9
  AST_PATHS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_req && no_retx)); // R10
endmodule

// File: tb/can_tx_abort_seq_bench.sv
module can_tx_abort_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic abort_req = 1'b0, abort_mode = 1'b0;
  logic tx_pending = 1'b0, tx_busy = 1'b0, run_status = 1'b1;
  logic stop_req, no_retx, lock_release, done, cancelled;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_abort_seq u_can_tx_abort_seq (
    .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .abort_mode(abort_mode),
    .tx_pending(tx_pending), .tx_busy(tx_busy), .run_status(run_status),
    .stop_req(stop_req), .no_retx(no_retx), .lock_release(lock_release),
    .done(done), .cancelled(cancelled)
  );

  // Reference model: a busy flag for the sequence, which path, and which step.
  bit    m_active = 0;
  bit    m_park = 0;
  string m_step = "none";
  bit    m_done = 0;
  bit    m_hit = 0;
  bit    m_busy_prev = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_park = 0; m_step = "none"; m_done = 0; m_hit = 0;
      m_busy_prev = 0;
    end else begin
      bit fell;
      fell = m_busy_prev && !tx_busy;
      if (m_done) begin
        m_done = 0; m_hit = 0;
      end else if (!m_active) begin
        if (abort_req) begin
          m_active = 1; m_park = abort_mode;
          m_step = abort_mode ? "wait_standby" : "wait_busy";
        end
      end else if (m_step == "freeing") begin
        if (!tx_pending) begin m_active = 0; m_done = 1; m_hit = 1; m_step = "none"; end
      end else if (m_park) begin
        if (!run_status) begin
          if (tx_pending) m_step = "freeing";
          else begin m_active = 0; m_done = 1; m_step = "none"; end
        end
      end else if (m_step == "wait_busy") begin
        if (tx_busy) m_step = "wait_fall";
        else if (!tx_pending) begin m_active = 0; m_done = 1; m_step = "none"; end
      end else begin
        if (fell) begin
          if (tx_pending) m_step = "freeing";
          else begin m_active = 0; m_done = 1; m_step = "none"; end
        end
      end
      m_busy_prev = tx_busy;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int lock_rises = 0;
  int done_count = 0;
  bit last_hit = 0;
  bit lock_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(stop_req == (m_active && m_park), "R2 stop_req", stop_req, m_active && m_park);
      check(no_retx == (m_active && !m_park), "R5 no_retx", no_retx, m_active && !m_park);
      check(lock_release == (m_step == "freeing"), "R6 lock_release", lock_release, m_step == "freeing");
      check(done == m_done, "R9 done", done, m_done);
      check(cancelled == m_hit, "R8 cancelled", cancelled, m_hit);
      if (lock_release && stop_req) check(!run_status, "R3 free while running", run_status, 0);
      if (lock_release && !lock_prev) lock_rises++;
      if (done) begin done_count++; last_hit = cancelled; end
      lock_prev = lock_release;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #(CLK_PERIOD/4); end
  endtask

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic start(input bit mode);
    abort_mode = mode; abort_req = 1; step(); abort_req = 0;
  endtask

  task automatic expect_end(input string req, input int rises, input bit hit, input int dones);
    check(lock_rises == rises, {req, " lock rises"}, lock_rises, rises);
    check(last_hit == hit, {req, " cancelled"}, last_hit, hit);
    check(done_count == dones, {req, " done count"}, done_count, dones);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_report();
  end

  initial begin
    step(2);
    // R1: outputs low during reset
    check({stop_req, no_retx, lock_release, done, cancelled} == 0, "R1 in reset",
          {stop_req, no_retx, lock_release, done, cancelled}, 0);
    rst_n = 1; step();
    check({stop_req, no_retx, lock_release, done, cancelled} == 0, "R1 after reset",
          {stop_req, no_retx, lock_release, done, cancelled}, 0);

    // R2 R3 R8: park path with pending frame
    run_status = 1; tx_pending = 1; tx_busy = 0;
    start(1);
    step(3); tx_busy = 1; step(2); tx_busy = 0;
    check(lock_release == 0, "R3 no free while running", lock_release, 0);
    run_status = 0; step(2);
    check(lock_release == 1, "R3 free after standby", lock_release, 1);
    tx_pending = 0; step(3);
    expect_end("R8 park hit", 1, 1, 1);
    run_status = 1;

    // R4: park path, frame already gone
    tx_pending = 1; start(1); step(2);
    tx_pending = 0; run_status = 0; step(3);
    expect_end("R4 park miss", 1, 0, 2);
    run_status = 1;

    // R6 R8: live path, arbitration lost then freed on busy falling edge
    tx_pending = 1; start(0); step(2);
    tx_busy = 1; step(4);
    check(lock_release == 0, "R6 no free while busy", lock_release, 0);
    tx_busy = 0; step();
    check(lock_release == 1, "R6 free after busy fall", lock_release, 1);
    step(2); tx_pending = 0; step(3);
    expect_end("R8 live hit", 2, 1, 3);

    // R7: live path, error with no retry (pending drops during busy)
    tx_pending = 1; start(0); tx_busy = 1; step(3);
    tx_pending = 0; step(2); tx_busy = 0; step(3);
    expect_end("R7 live error", 2, 0, 4);

    // R7: live path, pending drops without busy
    tx_pending = 1; start(0); step(2); tx_pending = 0; step(3);
    expect_end("R7 live no busy", 2, 0, 5);

    // R5: busy already high at request
    tx_pending = 1; tx_busy = 1; start(0);
    check(no_retx == 1, "R5 no_retx raised", no_retx, 1);
    step(2); tx_busy = 0; step(2); tx_pending = 0; step(3);
    expect_end("R5 live busy at start", 3, 1, 6);

    // R10: requests during a sequence and in the done cycle are ignored
    tx_pending = 1; start(0); abort_mode = 1; abort_req = 1; step(2);
    check(stop_req == 0, "R10 mid-sequence request", stop_req, 0);
    tx_pending = 0; step(1);
    check(done == 1, "R10 done cycle", done, 1);
    step(1); abort_req = 0; step(2);
    check(stop_req == 0 && no_retx == 0, "R10 done-cycle request ignored",
          stop_req | no_retx, 0);
    expect_end("R10 single done", 3, 0, 7);

    step(3);
    finish_report();
  end
endmodule